// File: doc/BRIEF.md
# Low-Order Interleaved Vector Memory

This block is a vector memory made of a parameterized number of identical banks (16 by default). Each bank takes one major cycle to finish an access. One major cycle equals as many clock cycles as there are banks. The banks are interleaved on the low-order address bits, so consecutive words sit in consecutive banks. A unit-stride vector access can therefore start a new bank access on every clock cycle (one minor cycle). The accesses overlap, and the results come out one per clock in element order.

A client issues a vector request: start address, element count and a read/write flag, with a valid/ready handshake. The request port stays closed until every bank access of the previous vector has finished. A read returns its elements on a response stream with valid/ready. When `rsp_ready` is low while `rsp_valid` is high, the whole access schedule freezes. The response then holds its data, and the schedule resumes as soon as `rsp_ready` returns. A write takes one element per accepted beat of the write-data stream. A beat moves when `wr_valid` and `wr_ready` are both high. A missing beat delays the launch of that element and of every later one, and a write returns no response.

Top module: `ilv_vec_mem`

## Requirements
- R1: Linear address `a` is held in bank `a mod NUM_BANKS` at word `a / NUM_BANKS`. With the defaults, bank = `a[3:0]` and word = `a[7:4]`, so address 17 is bank 1 word 1 and address 18 is bank 2 word 1. Element `k` of a vector uses address `start + k` modulo the memory size, so 255 is followed by 0.
- R2: A read is accepted at a rising edge E0 and streams without stalls. Element `k` is then presented on `rsp_valid` in the cycle after edge E0 + NUM_BANKS + k. The vector finishes NUM_BANKS + n − 1 cycles after its first bank access starts.
- R3: Read responses carry the stored word of each element, in element order, one response per element and no others.
- R4: `req_ready` is low from the cycle after acceptance until the last bank access of the vector has finished. Without stalls it returns high at edge E0 + NUM_BANKS + n. While it is low, `req_valid` has no effect.
- R5: A vector whose length equals NUM_BANKS occupies the memory for exactly two major cycles: `req_ready` returns high at edge E0 + 2·NUM_BANKS.
- R6: While `rsp_valid` is high and `rsp_ready` is low, the next cycle still shows `rsp_valid` high with unchanged `rsp_data`. No element is lost or duplicated.
- R7: A write vector takes exactly n beats from the write stream and stores them at `start + k` in beat order. A missing beat delays the schedule without losing data. `wr_ready` is high only while a write vector still has beats to take. A write never raises `rsp_valid`.
- R8: A request of length 0 is accepted and does nothing: `req_ready` stays high on the next cycle, no write beat is taken and no response appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one minor cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Vector request offered |
| req_ready | output | 1 | Request port open (no vector in flight) |
| req_addr | input | ADDR_W (8) | Start address of the vector |
| req_len | input | LEN_W (7) | Element count, 0 to MAX_LEN |
| req_write | input | 1 | 1 = write vector, 0 = read vector |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Write beat taken at this edge when wr_valid is high |
| wr_data | input | DATA_W (32) | Write beat data |
| rsp_valid | output | 1 | Read element present |
| rsp_ready | input | 1 | Consumer takes the read element |
| rsp_data | output | DATA_W (32) | Read element data |

## Verification
The bench builds the block with its defaults: 16 banks of 16 words, 32-bit data and at most 64 elements per vector. The whole 256-word space can be filled and read back, and vectors can cross the 255-to-0 wrap. A 64-element vector revisits every bank four times within one request, which exercises a bank being relaunched on the same edge its previous result is taken. Random back-pressure on the response and gaps in the write stream check that the frozen schedule keeps element order and timing.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;
endpackage

// File: rtl/ilv_issue.sv
module ilv_issue
  import ilv_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LEN_W     = 7,
  parameter int BANK_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LEN_W-1:0]      req_len,
  input  logic                  req_write,
  input  logic                  any_active,
  input  logic                  adv,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  output logic                  launch,
  output logic [BANK_BITS-1:0]  bank_sel,
  output logic [ADDR_W-BANK_BITS-1:0] word_sel,
  output op_e                   op
);
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  op_e               op_q;
  logic              req_fire;

  assign req_ready = !busy_q && !any_active;
  assign req_fire  = req_valid && req_ready;
  assign launch    = busy_q && adv && ((op_q == OP_READ) || wr_valid);
  assign wr_ready  = busy_q && adv && (op_q == OP_WRITE);
  assign bank_sel  = addr_q[BANK_BITS-1:0];
  assign word_sel  = addr_q[ADDR_W-1:BANK_BITS];
  assign op        = op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
      op_q   <= OP_READ;
    end else if (req_fire) begin
      busy_q <= (req_len != '0);
      addr_q <= req_addr;
      left_q <= req_len;
      op_q   <= req_write ? OP_WRITE : OP_READ;
    end else if (launch) begin
      addr_q <= addr_q + ADDR_W'(1);
      left_q <= left_q - LEN_W'(1);
      if (left_q == LEN_W'(1)) busy_q <= 1'b0;
    end
  end

  AST_WR_BEAT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && op_q == OP_WRITE) |-> wr_valid); // R7
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int NUM_BANKS = 16,
  parameter int WORDS     = 16,
  parameter int DATA_W    = 32,
  localparam int WORD_BITS = $clog2(WORDS),
  localparam int CNT_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 launch,
  input  logic                 we,
  input  logic [WORD_BITS-1:0] word,
  input  logic [DATA_W-1:0]    wdata,
  output logic                 active,
  output logic                 done_rd,
  output logic [DATA_W-1:0]    rdata
);
  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] rdata_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              active_q;
  logic              we_q;

  always_ff @(posedge clk) begin
    if (launch && we) mem[word] <= wdata;
    if (launch && !we) rdata_q <= mem[word];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      we_q     <= 1'b0;
    end else if (launch) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_W'(NUM_BANKS - 1);
      we_q     <= we;
    end else if (adv && active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - CNT_W'(1);
    end
  end

  assign active  = active_q;
  assign done_rd = active_q && (cnt_q == '0) && !we_q;
  assign rdata   = rdata_q;

  AST_BANK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (!active_q || (cnt_q == '0 && adv))); // R2
endmodule

// File: rtl/ilv_collect.sv
module ilv_collect #(
  parameter int NUM_BANKS = 16,
  parameter int DATA_W    = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_BANKS-1:0]              done_vec,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]  data_vec,
  output logic                              rsp_valid,
  output logic [DATA_W-1:0]                 rsp_data
);
  always_comb begin
    rsp_data = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (done_vec[b]) rsp_data = rsp_data | data_vec[b];
    end
  end
  assign rsp_valid = |done_vec;

  AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_vec)); // R3
endmodule

// File: rtl/ilv_vec_mem.sv
module ilv_vec_mem
  import ilv_pkg::*;
#(
  parameter int NUM_BANKS  = 16,
  parameter int BANK_WORDS = 16,
  parameter int DATA_W     = 32,
  parameter int MAX_LEN    = 64,
  localparam int BANK_BITS = $clog2(NUM_BANKS),
  localparam int WORD_BITS = $clog2(BANK_WORDS),
  localparam int ADDR_W    = BANK_BITS + WORD_BITS,
  localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  logic                              adv;
  logic                              launch;
  logic [BANK_BITS-1:0]              bank_sel;
  logic [WORD_BITS-1:0]              word_sel;
  op_e                               op;
  logic [NUM_BANKS-1:0]              active_vec;
  logic [NUM_BANKS-1:0]              done_vec;
  logic [NUM_BANKS-1:0][DATA_W-1:0]  data_vec;

  assign adv = !(rsp_valid && !rsp_ready);

  ilv_issue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BANK_BITS(BANK_BITS)) u_issue (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
    .any_active(|active_vec), .adv(adv),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .launch(launch), .bank_sel(bank_sel), .word_sel(word_sel), .op(op)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    ilv_bank #(.NUM_BANKS(NUM_BANKS), .WORDS(BANK_WORDS), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .launch(launch && (bank_sel == BANK_BITS'(g))),
      .we(op == OP_WRITE), .word(word_sel), .wdata(wr_data),
      .active(active_vec[g]), .done_rd(done_vec[g]), .rdata(data_vec[g])
    );
  end

  ilv_collect #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) u_collect (
    .clk(clk), .rst_n(rst_n),
    .done_vec(done_vec), .data_vec(data_vec),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R6
  AST_NO_ACCEPT_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R4
  AST_WR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !rsp_valid); // R7
endmodule

// File: tb/ilv_vec_mem_tb.sv
module ilv_vec_mem_tb;
  localparam int M = 16;
  localparam int MEMSZ = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic [6:0]  req_len = '0;
  logic        req_write = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;

  ilv_vec_mem u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  always #5 clk = ~clk;

  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  logic [31:0] model [MEMSZ];
  logic [31:0] exp_q [$];
  int          first_cyc = -1;
  int          last_cyc = -1;
  bit          bp_on = 1'b0;
  logic [7:0]  lfsr = 8'hA5;
  bit          prev_stall = 1'b0;
  logic [31:0] prev_data = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // back-pressure generator, changes away from the sampling edge
  always @(posedge clk) begin
    #1;
    if (bp_on) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rsp_ready = lfsr[0] | lfsr[2];
    end else begin
      rsp_ready = 1'b1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        checks++;
        if (!(rsp_valid && rsp_data == prev_data)) begin
          fails++;
          $display("FAIL R6 hold: actual valid=%0d data=%h expected valid=1 data=%h",
                   rsp_valid, rsp_data, prev_data);
        end
      end
      if (rsp_valid && rsp_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R3 unexpected response: actual %h expected none", rsp_data);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          if (rsp_data !== e) begin
            fails++;
            $display("FAIL R3 data: actual %h expected %h", rsp_data, e);
          end
        end
        if (first_cyc < 0) first_cyc = cyc;
        last_cyc = cyc;
      end
      prev_stall = rsp_valid && !rsp_ready;
      prev_data  = rsp_data;
    end
  end

  task automatic send_req(input int addr, input int len, input bit wr, output int acc);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 8'(addr); req_len = 7'(len); req_write = wr;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    acc = cyc;
  endtask

  task automatic wait_ready(output int rc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rc = cyc;
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
  endtask

  function automatic logic [31:0] pat(input int a, input int seed);
    return 32'(seed * 32'h01000193) ^ 32'(a * 32'h9E37) ^ 32'(a);
  endfunction

  task automatic wr_vec(input int addr, input int len, input int seed, input int gap_every,
                        output int acc);
    send_req(addr, len, 1'b1, acc);
    for (int k = 0; k < len; k++) begin
      if (gap_every != 0 && (k % gap_every) == 1) begin
        @(negedge clk); wr_valid = 1'b0;
      end
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = pat((addr + k) % MEMSZ, seed);
      #1;
      while (!wr_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      model[(addr + k) % MEMSZ] = pat((addr + k) % MEMSZ, seed);
    end
    @(negedge clk);
    wr_valid = 1'b0;
    chk(!wr_ready, "R7 wr_ready low after last beat", int'(wr_ready), 0);
  endtask

  task automatic rd_vec(input int addr, input int len, output int acc);
    for (int k = 0; k < len; k++) exp_q.push_back(model[(addr + k) % MEMSZ]);
    first_cyc = -1; last_cyc = -1;
    send_req(addr, len, 1'b0, acc);
  endtask

  initial begin
    int acc;
    int rc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R4 reset req_ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R3 reset rsp_valid", int'(rsp_valid), 0);
    chk(wr_ready == 1'b0, "R7 reset wr_ready", int'(wr_ready), 0);

    // fill whole memory; one vector with write-stream gaps (R7)
    wr_vec(0, 64, 1, 0, acc);
    wait_ready(rc);
    chk(rc == acc + M + 64, "R4 write vector release", rc - acc, M + 64);
    wr_vec(64, 64, 2, 3, acc);
    wr_vec(128, 64, 3, 0, acc);
    wr_vec(192, 64, 4, 0, acc);
    drain();

    // R2/R5: n = M from address 17 (bank 1 word 1) - R1
    rd_vec(17, 16, acc);
    wait_ready(rc);
    chk(first_cyc == acc + M, "R2 first element latency", first_cyc - acc, M);
    chk(last_cyc == acc + M + 15, "R2 last element latency", last_cyc - acc, M + 15);
    chk(rc == acc + 2 * M, "R5 two major cycles", rc - acc, 2 * M);
    drain();

    // single element at address 18 (bank 2 word 1) - R1
    rd_vec(18, 1, acc);
    wait_ready(rc);
    chk(first_cyc == acc + M, "R2 single element latency", first_cyc - acc, M);
    chk(rc == acc + M + 1, "R4 single element release", rc - acc, M + 1);
    drain();

    // wrap from 255 to 0 - R1
    rd_vec(250, 12, acc);
    drain();

    // longest vector, each bank reused four times, wraps - R1 R3
    rd_vec(200, 64, acc);
    wait_ready(rc);
    chk(last_cyc == acc + M + 63, "R2 max length last element", last_cyc - acc, M + 63);
    drain();

    // back-pressure - R6
    bp_on = 1'b1;
    rd_vec(5, 40, acc);
    drain();
    rd_vec(190, 64, acc);
    drain();
    bp_on = 1'b0;
    @(negedge clk);

    // overwrite a window, then read across its edges - R7 R3
    wr_vec(100, 20, 9, 4, acc);
    drain();
    rd_vec(95, 30, acc);
    drain();

    // request and write beats offered while busy are ignored - R4
    rd_vec(0, 20, acc);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 8'd0; req_len = 7'd5;
      wr_valid = 1'b1; wr_data = 32'hDEAD_BEEF;
      #1;
      chk(!req_ready, "R4 busy refuses request", int'(req_ready), 0);
      chk(!wr_ready, "R4 busy takes no beat", int'(wr_ready), 0);
    end
    @(negedge clk);
    req_valid = 1'b0; wr_valid = 1'b0;
    drain();
    rd_vec(0, 5, acc);
    drain();

    // zero length - R8
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 32'h0BAD_F00D;
    send_req(7, 0, 1'b1, acc);
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 zero length leaves port open", int'(req_ready), 1);
    chk(wr_ready == 1'b0, "R8 zero length takes no beat", int'(wr_ready), 0);
    chk(rsp_valid == 1'b0, "R8 zero length no response", int'(rsp_valid), 0);
    wr_valid = 1'b0;
    rd_vec(7, 1, acc);
    drain();

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all responses received", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule